// File: doc/BRIEF.md
# Flat-Field and Tap-Balance Pixel Corrector

This block corrects raw line-scan samples on their way to the video output. A 14-bit sample arrives with its position in the line. The block first removes a per-pixel dark offset and applies a per-pixel gain coefficient. It then applies a fine gain trim and a clamp trim chosen by the tap that the pixel belongs to. After that come a global digital gain and a global offset. The result is clipped to a 12-bit value. The pixel coefficients are held in an internal register array whose depth is set by a parameter. Software can load that array, clear the offsets, or restore every gain to unity.

A one-push calibration computes the gain coefficients. After a start pulse, the block captures the next complete line, beginning at pixel 0, from a white reference. It then works through the pixels one at a time with a serial divider and sets each coefficient to target divided by measured level. The target is always given in 12-bit units, whatever the final output depth: for 10-bit output it is the wanted level times 4, and for 8-bit output it is the wanted level times 16. When the run ends, two flags report whether any pixel could not reach the target or whether any pixel was at full scale during capture. An abort pulse stops a run at once.

Top module: `ffc_corrector`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `cal_busy`, `cal_high` and `cal_low` are 0. Every offset coefficient is 0 and every gain coefficient is 1024, which is unity in the Q2.10 format.
- R2: A pixel sampled with `pix_valid` at a clock edge produces `out_valid`=1 after the next edge, so the output is seen two cycles after the input is presented. The output value is computed as follows: lvl = raw − off; b = floor(lvl·gain/4096); c = floor(b·(4096+tg)/4096) + tc; e = floor(c·(64+dgain)/64) + goffs.
- R3: The output value is e limited to the range 0..4095. A negative e gives 0 and any e above 4095 gives 4095.
- R4: The tap of a pixel is pix_idx / (NPIX/NTAPS). Its gain trim tg and clamp trim tc are the signed bytes at bits [8·tap+7 : 8·tap] of `tap_gain` and `tap_clamp`.
- R5: When `coef_we` is 1, the signed offset `coef_off` and the Q2.10 gain `coef_gain` are written to entry `coef_addr`. A pixel sampled in that same cycle still uses the old values.
- R6: `clr_off` sets every offset to 0 and `clr_gain` sets every gain to 1024. Each takes priority over a write to the same array in the same cycle.
- R7: A `cal_start` pulse while idle raises `cal_busy` after the next edge. The block then captures pixels 0..NPIX−1 of the next line, starting at pixel 0. For each pixel it writes the gain floor(`cal_target`·4096 / m), where m = raw − offset of the captured sample. When the last gain is written, `cal_busy` returns to 0.
- R8: Two cases make the run store a gain of 4095 and set `cal_low`: m ≤ 0, or a quotient greater than 4095. A run in which no pixel meets either case clears `cal_low`.
- R9: If any captured raw sample equals 16383, the run sets `cal_high`. A run without such a sample clears it.
- R10: `cal_abort` while busy clears `cal_busy` after the next edge. Both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Input sample valid |
| pix_idx | input | IW | Pixel position in the line |
| pix_raw | input | 14 | Raw sample |
| dgain | input | 8 | Digital gain, factor 1+dgain/64 |
| goffs | input | 13 | Signed global offset, 12-bit LSB |
| tap_gain | input | NTAPS·8 | Signed per-tap gain trims |
| tap_clamp | input | NTAPS·8 | Signed per-tap clamp trims |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | IW | Coefficient entry |
| coef_off | input | 8 | Signed offset to write |
| coef_gain | input | 12 | Q2.10 gain to write |
| clr_off | input | 1 | Clear all offsets |
| clr_gain | input | 1 | Set all gains to unity |
| cal_start | input | 1 | Start calibration |
| cal_abort | input | 1 | Abort calibration |
| cal_target | input | 12 | Calibration target, 12-bit units |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 12 | Corrected sample |
| cal_busy | output | 1 | Calibration running |
| cal_high | output | 1 | Full-scale sample seen in last run |
| cal_low | output | 1 | Target unreachable in last run |

## Verification
Corrected pixels are due two cycles after they are presented. The bench's reference model keeps a two-entry queue. It applies the tap, digital gain and offset settings that are present at the second edge, and compares `out_valid` and `out_data` at every falling edge. A start pulse or an abort pulse changes `cal_busy` after one edge, and the bench checks that on the following falling edge. Each gain takes 25 cycles to compute after capture, so the bench waits for `cal_busy` to fall and then reads the flags in that same cycle. It then confirms the new gains by streaming a line through the corrector.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int RAW_W     = 14;
  localparam int OUT_W     = 12;
  localparam int GAIN_W    = 12;
  localparam int GAIN_FRAC = 10;
  localparam int MEAS_W    = 16;
  localparam int MID_W     = 18;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = 12'd1024;
  localparam logic [GAIN_W-1:0] GAIN_MAX   = 12'hFFF;

  typedef logic signed [39:0] wide_t;
  typedef enum logic [1:0] {C_IDLE, C_CAPT, C_DIV} cal_st_t;

  // raw sample minus the per-pixel dark offset
  function automatic logic signed [MEAS_W-1:0] pre_level(logic [RAW_W-1:0] raw,
                                                        logic signed [7:0] off);
    wide_t a;
    a = wide_t'({26'd0, raw}) - wide_t'(off);
    return a[MEAS_W-1:0];
  endfunction

  // Q2.10 pixel gain, combined with the 14-to-12 bit scale
  function automatic logic signed [MID_W-1:0] pixel_scale(logic signed [MEAS_W-1:0] lvl,
                                                          logic [GAIN_W-1:0] g);
    wide_t p;
    p = (wide_t'(lvl) * wide_t'({28'd0, g})) >>> (GAIN_FRAC + 2);
    return p[MID_W-1:0];
  endfunction

  // tap trims, digital gain, global offset, clip to 12 bits
  function automatic logic [OUT_W-1:0] tail_stage(logic signed [MID_W-1:0] b,
                                                  logic signed [7:0] tg,
                                                  logic signed [7:0] tc,
                                                  logic [7:0] dg,
                                                  logic signed [12:0] go);
    wide_t c, e;
    c = ((wide_t'(b) * (wide_t'(4096) + wide_t'(tg))) >>> 12) + wide_t'(tc);
    e = ((c * (wide_t'(64) + wide_t'({32'd0, dg}))) >>> 6) + wide_t'(go);
    if (e < 0) return '0;
    if (e > 4095) return '1;
    return e[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/ffc_coef_store.sv
module ffc_coef_store import ffc_pkg::*; #(
  parameter int NPIX = 16,
  localparam int IW = $clog2(NPIX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IW-1:0]           rd_addr,
  output logic signed [7:0]       rd_off,
  output logic [GAIN_W-1:0]       rd_gain,
  input  logic                    host_we,
  input  logic [IW-1:0]           host_addr,
  input  logic signed [7:0]       host_off,
  input  logic [GAIN_W-1:0]       host_gain,
  input  logic                    cal_we,
  input  logic [IW-1:0]           cal_addr,
  input  logic [GAIN_W-1:0]       cal_gain,
  input  logic                    clr_off,
  input  logic                    clr_gain
);
  logic signed [7:0]  off_q  [NPIX];
  logic [GAIN_W-1:0]  gain_q [NPIX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) begin
        off_q[i]  <= '0;
        gain_q[i] <= GAIN_UNITY;
      end
    end else begin
      for (int i = 0; i < NPIX; i++) begin
        if (clr_off) off_q[i] <= '0;
        else if (host_we && host_addr == IW'(i)) off_q[i] <= host_off;
        if (clr_gain) gain_q[i] <= GAIN_UNITY;
        else if (cal_we && cal_addr == IW'(i)) gain_q[i] <= cal_gain;
        else if (host_we && host_addr == IW'(i)) gain_q[i] <= host_gain;
      end
    end
  end

  assign rd_off  = off_q[rd_addr];
  assign rd_gain = gain_q[rd_addr];

  // R6
  clr_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_gain |=> (gain_q[0] == GAIN_UNITY && gain_q[NPIX-1] == GAIN_UNITY));
  // R6
  clr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_off |=> (off_q[0] == 8'sd0 && off_q[NPIX-1] == 8'sd0));
endmodule

// File: rtl/ffc_datapath.sv
module ffc_datapath import ffc_pkg::*; #(
  parameter int NPIX  = 16,
  parameter int NTAPS = 4,
  localparam int IW      = $clog2(NPIX),
  localparam int TW      = $clog2(NTAPS),
  localparam int PER_TAP = NPIX / NTAPS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IW-1:0]            in_idx,
  input  logic [RAW_W-1:0]         in_raw,
  input  logic signed [7:0]        coef_off,
  input  logic [GAIN_W-1:0]        coef_gain,
  input  logic [NTAPS*8-1:0]       tap_gain,
  input  logic [NTAPS*8-1:0]       tap_clamp,
  input  logic [7:0]               dgain,
  input  logic signed [12:0]       goffs,
  output logic                     s1_valid,
  output logic [IW-1:0]            s1_idx,
  output logic signed [MEAS_W-1:0] s1_meas,
  output logic                     s1_full,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_data
);
  logic signed [MEAS_W-1:0] lvl;
  logic signed [MID_W-1:0]  s1_mid;
  logic [TW-1:0]            s1_tap;
  logic signed [7:0]        sel_tg, sel_tc;

  assign lvl = pre_level(in_raw, coef_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_meas  <= '0;
      s1_mid   <= '0;
      s1_full  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_idx  <= in_idx;
        s1_meas <= lvl;
        s1_mid  <= pixel_scale(lvl, coef_gain);
        s1_full <= &in_raw;
      end
    end
  end

  assign s1_tap = TW'(s1_idx / IW'(PER_TAP));
  assign sel_tg = $signed(tap_gain[s1_tap*8 +: 8]);
  assign sel_tc = $signed(tap_clamp[s1_tap*8 +: 8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= tail_stage(s1_mid, sel_tg, sel_tc, dgain, goffs);
    end
  end

  // R2
  out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
endmodule

// File: rtl/ffc_calib.sv
module ffc_calib import ffc_pkg::*; #(
  parameter int NPIX = 16,
  localparam int IW = $clog2(NPIX),
  localparam int QW = OUT_W + 12,
  localparam int SW = $clog2(QW + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     abort,
  input  logic [OUT_W-1:0]         target,
  input  logic                     s1_valid,
  input  logic [IW-1:0]            s1_idx,
  input  logic signed [MEAS_W-1:0] s1_meas,
  input  logic                     s1_full,
  output logic                     cal_we,
  output logic [IW-1:0]            cal_addr,
  output logic [GAIN_W-1:0]        cal_gain,
  output logic                     busy,
  output logic                     flag_high,
  output logic                     flag_low
);
  cal_st_t                  state;
  logic signed [MEAS_W-1:0] cap_m [NPIX];
  logic [NPIX-1:0]          cap_f;
  logic                     capturing, low_acc, high_acc;
  logic [IW-1:0]            pix;
  logic [SW-1:0]            step;
  logic [MEAS_W-1:0]        rem;
  logic [QW-2:0]            quo;
  logic signed [MEAS_W-1:0] dvs;

  logic [QW-1:0]   num;
  logic [SW-1:0]   bit_pos;
  logic [MEAS_W:0] rem_sh, dvs_ext;
  logic            ge, bad, cap_we, last_step, done_ev;
  logic [MEAS_W-1:0] rem_n;
  logic [QW-1:0]   quo_n;

  assign num      = {target, 12'd0};
  assign bit_pos  = SW'(QW) - step;
  assign rem_sh   = {rem, num[bit_pos]};
  assign dvs_ext  = {1'b0, dvs};
  assign ge       = rem_sh >= dvs_ext;
  assign rem_n    = ge ? MEAS_W'(rem_sh - dvs_ext) : rem_sh[MEAS_W-1:0];
  assign quo_n    = {quo, ge};
  assign bad      = (dvs <= 0) || (quo_n > QW'(GAIN_MAX));

  assign cap_we    = (state == C_CAPT) && !abort && s1_valid && (capturing || s1_idx == '0);
  assign last_step = (state == C_DIV) && !abort && (step == SW'(QW));
  assign done_ev   = last_step && (pix == IW'(NPIX - 1));

  assign cal_we   = last_step;
  assign cal_addr = pix;
  assign cal_gain = bad ? GAIN_MAX : quo_n[GAIN_W-1:0];
  assign busy     = (state != C_IDLE);

  always_ff @(posedge clk) begin
    if (cap_we) begin
      cap_m[s1_idx] <= s1_meas;
      cap_f[s1_idx] <= s1_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= C_IDLE; capturing <= 1'b0; low_acc <= 1'b0; high_acc <= 1'b0;
      pix <= '0; step <= '0; rem <= '0; quo <= '0; dvs <= '0;
      flag_high <= 1'b0; flag_low <= 1'b0;
    end else begin
      case (state)
        C_IDLE: if (start) begin
          state <= C_CAPT; capturing <= 1'b0; low_acc <= 1'b0; high_acc <= 1'b0;
        end
        C_CAPT: if (abort) state <= C_IDLE;
          else if (cap_we) begin
            capturing <= 1'b1;
            if (s1_idx == IW'(NPIX - 1)) begin
              state <= C_DIV; pix <= '0; step <= '0;
            end
          end
        default: if (abort) state <= C_IDLE;
          else if (step == '0) begin
            rem <= '0; quo <= '0; dvs <= cap_m[pix]; step <= SW'(1);
          end else begin
            rem <= rem_n; quo <= quo_n[QW-2:0];
            if (last_step) begin
              step     <= '0;
              low_acc  <= low_acc | bad;
              high_acc <= high_acc | cap_f[pix];
              if (done_ev) begin
                state     <= C_IDLE;
                flag_low  <= low_acc | bad;
                flag_high <= high_acc | cap_f[pix];
              end else pix <= pix + 1'b1;
            end else step <= step + 1'b1;
          end
      endcase
    end
  end

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> !busy);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable({flag_low, flag_high}));
  // R8
  sat_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_we && dvs <= 0) |-> cal_gain == GAIN_MAX);
endmodule

// File: rtl/ffc_corrector.sv
module ffc_corrector import ffc_pkg::*; #(
  parameter int NPIX  = 16,
  parameter int NTAPS = 4,
  localparam int IW = $clog2(NPIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic [IW-1:0]      pix_idx,
  input  logic [13:0]        pix_raw,
  input  logic [7:0]         dgain,
  input  logic signed [12:0] goffs,
  input  logic [NTAPS*8-1:0] tap_gain,
  input  logic [NTAPS*8-1:0] tap_clamp,
  input  logic               coef_we,
  input  logic [IW-1:0]      coef_addr,
  input  logic signed [7:0]  coef_off,
  input  logic [11:0]        coef_gain,
  input  logic               clr_off,
  input  logic               clr_gain,
  input  logic               cal_start,
  input  logic               cal_abort,
  input  logic [11:0]        cal_target,
  output logic               out_valid,
  output logic [11:0]        out_data,
  output logic               cal_busy,
  output logic               cal_high,
  output logic               cal_low
);
  logic signed [7:0]        rd_off;
  logic [GAIN_W-1:0]        rd_gain;
  logic                     s1_valid, s1_full, cw_we;
  logic [IW-1:0]            s1_idx, cw_addr;
  logic signed [MEAS_W-1:0] s1_meas;
  logic [GAIN_W-1:0]        cw_gain;

  ffc_coef_store #(.NPIX(NPIX)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(pix_idx), .rd_off(rd_off), .rd_gain(rd_gain),
    .host_we(coef_we), .host_addr(coef_addr), .host_off(coef_off), .host_gain(coef_gain),
    .cal_we(cw_we), .cal_addr(cw_addr), .cal_gain(cw_gain),
    .clr_off(clr_off), .clr_gain(clr_gain));

  ffc_datapath #(.NPIX(NPIX), .NTAPS(NTAPS)) u_path (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_idx(pix_idx), .in_raw(pix_raw),
    .coef_off(rd_off), .coef_gain(rd_gain), .tap_gain(tap_gain), .tap_clamp(tap_clamp),
    .dgain(dgain), .goffs(goffs), .s1_valid(s1_valid), .s1_idx(s1_idx),
    .s1_meas(s1_meas), .s1_full(s1_full), .out_valid(out_valid), .out_data(out_data));

  ffc_calib #(.NPIX(NPIX)) u_cal (
    .clk(clk), .rst_n(rst_n), .start(cal_start), .abort(cal_abort), .target(cal_target),
    .s1_valid(s1_valid), .s1_idx(s1_idx), .s1_meas(s1_meas), .s1_full(s1_full),
    .cal_we(cw_we), .cal_addr(cw_addr), .cal_gain(cw_gain),
    .busy(cal_busy), .flag_high(cal_high), .flag_low(cal_low));
endmodule

// File: tb/sim_ffc_corrector.sv
module sim_ffc_corrector;
  localparam int NPIX = 16;
  localparam int NTAPS = 4;
  localparam int IW = $clog2(NPIX);
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic [IW-1:0] pix_idx = '0;
  logic [13:0] pix_raw = '0;
  logic [7:0] dgain = '0;
  logic signed [12:0] goffs = '0;
  logic [NTAPS*8-1:0] tap_gain = '0, tap_clamp = '0;
  logic coef_we = 1'b0;
  logic [IW-1:0] coef_addr = '0;
  logic signed [7:0] coef_off = '0;
  logic [11:0] coef_gain = '0;
  logic clr_off = 1'b0, clr_gain = 1'b0, cal_start = 1'b0, cal_abort = 1'b0;
  logic [11:0] cal_target = '0;
  logic out_valid, cal_busy, cal_high, cal_low;
  logic [11:0] out_data;

  always #5 clk = ~clk;

  ffc_corrector #(.NPIX(NPIX), .NTAPS(NTAPS)) u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R2";
  int off_m[NPIX], gain_m[NPIX], tg[NTAPS], tc[NTAPS], line_d[NPIX];
  int dg_i = 0, go_i = 0;
  bit m1_v = 0, m2_v = 0;
  int m1_b = 0, m1_t = 0, m2_d = 0;

  function automatic int fdiv(int a, int b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  function automatic int fin_of(int b, int t);
    int v;
    v = fdiv(b * (4096 + tg[t]), 4096) + tc[t];
    v = fdiv(v * (64 + dg_i), 64) + go_i;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic apply_params();
    dgain = 8'(dg_i);
    goffs = 13'(go_i);
    for (int t = 0; t < NTAPS; t++) begin
      tap_gain[t*8 +: 8]  = 8'(tg[t]);
      tap_clamp[t*8 +: 8] = 8'(tc[t]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    if (m1_v) m2_d = fin_of(m1_b, m1_t);
    m2_v = m1_v;
    m1_v = pix_valid;
    if (pix_valid) begin
      m1_b = fdiv((int'(pix_raw) - off_m[int'(pix_idx)]) * gain_m[int'(pix_idx)], 4096);
      m1_t = int'(pix_idx) / (NPIX / NTAPS);
    end
    for (int i = 0; i < NPIX; i++) begin
      if (clr_off) off_m[i] = 0;
      else if (coef_we && int'(coef_addr) == i) off_m[i] = int'(coef_off);
      if (clr_gain) gain_m[i] = 1024;
      else if (coef_we && int'(coef_addr) == i) gain_m[i] = int'(coef_gain);
    end
    @(negedge clk);
    chk(out_valid == m2_v, {cur_tag, " out_valid"}, int'(out_valid), int'(m2_v));
    if (m2_v) chk(int'(out_data) == m2_d, {cur_tag, " out_data"}, int'(out_data), m2_d);
    if (cyc > WDOG) begin
      chk(1'b0, "R7 watchdog", cyc, WDOG);
      finish_run();
    end
  endtask

  task automatic send_line();
    for (int i = 0; i < NPIX; i++) begin
      pix_valid = 1'b1; pix_idx = IW'(i); pix_raw = 14'(line_d[i]);
      tick();
    end
    pix_valid = 1'b0;
    tick(); tick();
  endtask

  task automatic run_cal(int tgt, string req);
    int exp_g[NPIX];
    int m, q;
    bit lo, hi;
    cal_target = 12'(tgt); cal_start = 1'b1;
    tick();
    cal_start = 1'b0;
    chk(cal_busy == 1'b1, "R7 busy after start", int'(cal_busy), 1);
    send_line();
    for (int k = 0; k < 2000 && cal_busy; k++) tick();
    chk(cal_busy == 1'b0, "R7 busy at end", int'(cal_busy), 0);
    lo = 0; hi = 0;
    for (int i = 0; i < NPIX; i++) begin
      m = line_d[i] - off_m[i];
      if (m <= 0) begin q = 4095; lo = 1; end
      else begin
        q = (tgt * 4096) / m;
        if (q > 4095) begin q = 4095; lo = 1; end
      end
      if (line_d[i] == 16383) hi = 1;
      exp_g[i] = q;
    end
    chk(cal_low == lo, "R8 low flag", int'(cal_low), int'(lo));
    chk(cal_high == hi, "R9 high flag", int'(cal_high), int'(hi));
    for (int i = 0; i < NPIX; i++) gain_m[i] = exp_g[i];
    cur_tag = req;
    for (int i = 0; i < NPIX; i++) line_d[i] = 2000 + i * 650;
    send_line();
  endtask

  initial begin
    for (int i = 0; i < NPIX; i++) begin off_m[i] = 0; gain_m[i] = 1024; end
    for (int t = 0; t < NTAPS; t++) begin tg[t] = 0; tc[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(cal_busy == 1'b0, "R1 busy", int'(cal_busy), 0);
    chk(cal_high == 1'b0, "R1 high", int'(cal_high), 0);
    chk(cal_low == 1'b0, "R1 low", int'(cal_low), 0);
    rst_n = 1'b1;
    tick();
    // R1: unity gains and zero offsets after reset
    cur_tag = "R1";
    for (int i = 0; i < NPIX; i++) line_d[i] = i * 1021 + 5;
    send_line();
    // R5: host coefficient load, then a line that uses it
    cur_tag = "R5";
    for (int i = 0; i < NPIX; i++) begin
      coef_we = 1'b1; coef_addr = IW'(i);
      coef_off = 8'(i * 13 - 100); coef_gain = 12'(512 + i * 200);
      if (i == 3) begin pix_valid = 1'b1; pix_idx = IW'(3); pix_raw = 14'd9000; end
      else pix_valid = 1'b0;
      tick();
    end
    coef_we = 1'b0; pix_valid = 1'b0;
    line_d[3] = 0; line_d[NPIX-1] = 10;
    send_line();
    // R3: negative results clip to 0 (pixel NPIX-1 sits below its offset)
    cur_tag = "R3";
    send_line();
    // R4: per-tap trims with digital gain and global offset
    cur_tag = "R4";
    tg[0] = -128; tg[1] = 127; tg[2] = 0; tg[3] = 50;
    tc[0] = -128; tc[1] = 127; tc[2] = 5; tc[3] = -3;
    dg_i = 255; go_i = -200;
    apply_params();
    send_line();
    // R2: mixed pattern
    cur_tag = "R2";
    dg_i = 17; go_i = 33; apply_params();
    for (int i = 0; i < NPIX; i++) line_d[i] = (i * 7919) % 16384;
    send_line();
    // R3: high and low saturation
    cur_tag = "R3";
    dg_i = 0; go_i = 4095; apply_params();
    send_line();
    go_i = -4096; apply_params();
    send_line();
    for (int t = 0; t < NTAPS; t++) begin tg[t] = 0; tc[t] = 0; end
    dg_i = 0; go_i = 0; apply_params();
    // R6: clears take priority over a host write in the same cycle
    cur_tag = "R6";
    clr_off = 1'b1; clr_gain = 1'b1; coef_we = 1'b1; coef_addr = IW'(2);
    coef_off = 8'sd50; coef_gain = 12'd77;
    tick();
    clr_off = 1'b0; clr_gain = 1'b0; coef_we = 1'b0;
    for (int i = 0; i < NPIX; i++) line_d[i] = 500 + i * 900;
    send_line();
    // R7: clean calibration
    for (int i = 0; i < NPIX; i++) line_d[i] = 3100 + i * 700;
    run_cal(3000, "R7");
    // R8 and R9: zero level and full-scale pixel
    for (int i = 0; i < NPIX; i++) line_d[i] = 3100 + i * 700;
    line_d[0] = 0; line_d[1] = 16383;
    run_cal(4000, "R8");
    // R10: abort during capture keeps flags and gains
    cal_target = 12'd2000; cal_start = 1'b1;
    tick();
    cal_start = 1'b0; cal_abort = 1'b1;
    tick();
    cal_abort = 1'b0;
    chk(cal_busy == 1'b0, "R10 busy after abort", int'(cal_busy), 0);
    chk(cal_low == 1'b1, "R10 low kept", int'(cal_low), 1);
    chk(cal_high == 1'b1, "R10 high kept", int'(cal_high), 1);
    cur_tag = "R10";
    for (int i = 0; i < NPIX; i++) line_d[i] = 2500 + i * 600;
    send_line();
    chk(cal_busy == 1'b0, "R10 no capture after abort", int'(cal_busy), 0);
    // R8: clean run clears both flags (10-bit level 256 given as 1024)
    for (int i = 0; i < NPIX; i++) line_d[i] = 3100 + i * 700;
    run_cal(1024, "R8");
    finish_run();
  end
endmodule